// File: doc/BRIEF.md
# Multithreaded Instruction Fetch Queue

This block is the fetch and buffering stage of a barrel-style multithreaded processor. It keeps a pool of thread contexts. Each context holds a thread number and an instruction pointer. A small number of these threads are active at once, and each active thread owns one opcode queue. The fetcher reads 64-bit words from an instruction memory port. It serves the active queues in turn, using every read slot the memory grants, and it tags each stored word with the thread number of its owner. Decode drains the queues through a valid/ready port, one tagged word at a time.

Each fetched word is scanned for a branch before it is stored. A thread that has fetched a branch gets a fixed number of further words. After that it leaves the active set, and the oldest waiting thread takes its place, so decode is not left waiting on one stalled thread. A long-latency miss also forces a rotation: the missed word is dropped and the thread goes back to the pool, where it will fetch the same address again later. A thread that left with a branch still open is parked. It rejoins the pool only after decode writes back the resolved target through the branch-resolve port.

Top module: `mt_fetch_queue`

## Requirements
- R1: While reset is held, and on the first cycle after it, `op_valid_o` and `mem_req_o` are low. After reset every context is null and every queue is empty.
- R2: A context write with `ctx_ld_valid_i` to a null context makes it live, gives it the start address, and puts it at the tail of the ready order. A context write to a live context is ignored, and the thread keeps its current pointer.
- R3: A null context is never scheduled, so `mem_req_o` stays low until at least one context has been written.
- R4: At most NUM_ACT (4) threads are active at once. Admission moves the oldest waiting thread into the lowest-numbered free active slot, one admission per cycle, and it takes the pointer stored in that thread's context.
- R5: The fetcher serves occupied slots whose queue is not full, starting from the slot after the last one served. `mem_addr_o` is that slot's pointer. A word is accepted when `mem_req_o` and `mem_gnt_i` are both high. Each accepted word that is not a miss advances the pointer by 8.
- R6: Each queue holds Q_WORDS (4) words of 64 bits. No request is made on behalf of a full queue.
- R7: Every word delivered on `op_word_o` comes with `op_tid_o` set to the thread that fetched it. Words from one queue are delivered in fetch order.
- R8: A word is a branch word when any of its four 16-bit lanes (bits 16k+15 down to 16k) has 4'hF in its top four bits. After a branch word is stored, the thread stores exactly 2 more words and then leaves the active set.
- R9: A word returned with `mem_miss_i` high is not stored and its thread leaves the active set. If no branch is open for that thread, the missed address is kept as the thread's pointer.
- R10: A thread that leaves with an unresolved branch is parked and is not admitted again. A write on `br_res_*` to a live context sets its pointer, closes the branch, and moves a parked thread to the ready tail.
- R11: The output is valid whenever any queue holds data. Queues are served round-robin starting after the last one popped, and empty queues are skipped. While `op_ready_i` is low, the presented word and tag stay unchanged.
- R12: A thread that leaves without an open branch goes to the ready tail. When several threads join in one cycle, the order is: newly written context, then resolved parked thread, then retiring thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_ld_valid_i | input | 1 | Context write strobe |
| ctx_ld_tid_i | input | 4 | Thread written |
| ctx_ld_ip_i | input | 32 | Start address for that thread |
| br_res_valid_i | input | 1 | Resolved-branch strobe |
| br_res_tid_i | input | 4 | Thread whose branch resolved |
| br_res_ip_i | input | 32 | Resolved target address |
| mem_req_o | output | 1 | Fetch request |
| mem_addr_o | output | 32 | Byte address of the requested word |
| mem_gnt_i | input | 1 | Read slot granted this cycle |
| mem_rdata_i | input | 64 | Word for `mem_addr_o`, same cycle |
| mem_miss_i | input | 1 | Word is a long-latency miss |
| op_valid_o | output | 1 | Output word available |
| op_ready_i | input | 1 | Decode takes the word |
| op_word_o | output | 64 | Fetched word |
| op_tid_o | output | 4 | Thread that owns the word |

## Verification
The embedded assertions check the local invariants on every cycle. No queue is written when full or read when empty, the output is held while decode stalls, at most one queue pops per cycle, and a slot's pointer steps by one word after each stored fetch. They also check that a miss, or the last post-branch word, frees the slot on the next cycle, that the ready order never holds more entries than there are contexts, and that a retiring thread is never one that is already parked. Several behaviours span many cycles and many threads, and only the bench's reference model can show them. These are the order in which threads are admitted and requeued, that a parked thread stays out until its resolve arrives, that a missed address is fetched again after readmission, that an ignored context write leaves the pointer alone, and the exact round-robin interleaving of tagged words at the output.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
   localparam int OP_W = 16;
   localparam int TAG_NIB = 4;

   typedef enum logic [1:0] {
      LEAVE_NONE,
      LEAVE_BRANCH,
      LEAVE_MISS
   } leave_e;

   function automatic logic lane_is_branch(input logic [OP_W-1:0] op,
                                           input logic [TAG_NIB-1:0] code);
      return op[OP_W-1 -: TAG_NIB] == code;
   endfunction
endpackage

// File: rtl/mtf_ctx_pool.sv
module mtf_ctx_pool #(
   parameter int NUM_CTX = 16,
   parameter int ADDR_W  = 32,
   localparam int TID_W  = $clog2(NUM_CTX),
   localparam int CNT_W  = TID_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [TID_W-1:0]  ld_tid,
   input  logic [ADDR_W-1:0] ld_ip,
   input  logic              rs_valid,
   input  logic [TID_W-1:0]  rs_tid,
   input  logic [ADDR_W-1:0] rs_ip,
   input  logic              mark_valid,
   input  logic [TID_W-1:0]  mark_tid,
   input  logic              ret_valid,
   input  logic [TID_W-1:0]  ret_tid,
   input  logic              ret_wb,
   input  logic [ADDR_W-1:0] ret_ip,
   input  logic              adm_pop,
   output logic              adm_avail,
   output logic [TID_W-1:0]  adm_tid,
   output logic [ADDR_W-1:0] adm_ip
);
   if (NUM_CTX != (1 << TID_W)) begin : g_bad_ctx
      $error("NUM_CTX must be a power of two");
   end

   logic [NUM_CTX-1:0] c_live, c_pend, c_park;
   logic [ADDR_W-1:0]  c_ip [NUM_CTX];
   logic [TID_W-1:0]   order_q [NUM_CTX];
   logic [TID_W-1:0]   head;
   logic [CNT_W-1:0]   cnt;

   logic ld_ok, rs_ok, unpark, ret_pend, park;
   logic [2:0]       join_en;
   logic [TID_W-1:0] join_tid [3];
   logic [TID_W-1:0] join_pos [3];
   logic [TID_W-1:0] tail;
   logic [CNT_W-1:0] n_join;

   always_comb begin
      ld_ok    = ld_valid && !c_live[ld_tid];
      rs_ok    = rs_valid && c_live[rs_tid];
      unpark   = rs_ok && c_park[rs_tid];
      ret_pend = c_pend[ret_tid] || (mark_valid && mark_tid == ret_tid);
      park     = ret_valid && ret_pend && !(rs_ok && rs_tid == ret_tid);
      join_en     = {ret_valid && !park, unpark, ld_ok};
      join_tid[0] = ld_tid;
      join_tid[1] = rs_tid;
      join_tid[2] = ret_tid;
      tail        = head + cnt[TID_W-1:0];
      join_pos[0] = tail;
      join_pos[1] = tail + TID_W'(join_en[0]);
      join_pos[2] = tail + TID_W'(join_en[0]) + TID_W'(join_en[1]);
      n_join      = CNT_W'(join_en[0]) + CNT_W'(join_en[1]) + CNT_W'(join_en[2]);
   end

   assign adm_avail = cnt != '0;
   assign adm_tid   = order_q[head];
   assign adm_ip    = c_ip[order_q[head]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_live <= '0;
         c_pend <= '0;
         c_park <= '0;
         head   <= '0;
         cnt    <= '0;
         for (int i = 0; i < NUM_CTX; i++) begin
            c_ip[i]    <= '0;
            order_q[i] <= '0;
         end
      end else begin
         cnt  <= cnt + n_join - CNT_W'(adm_pop);
         head <= head + TID_W'(adm_pop);
         for (int k = 0; k < 3; k++) begin
            if (join_en[k]) order_q[join_pos[k]] <= join_tid[k];
         end
         if (ld_ok) begin
            c_live[ld_tid] <= 1'b1;
            c_ip[ld_tid]   <= ld_ip;
            c_pend[ld_tid] <= 1'b0;
            c_park[ld_tid] <= 1'b0;
         end
         if (mark_valid) c_pend[mark_tid] <= 1'b1;
         if (park) c_park[ret_tid] <= 1'b1;
         if (ret_valid && ret_wb) c_ip[ret_tid] <= ret_ip;
         if (rs_ok) begin
            c_ip[rs_tid]   <= rs_ip;
            c_pend[rs_tid] <= 1'b0;
            if (unpark) c_park[rs_tid] <= 1'b0;
         end
      end
   end

   // R12
   pool_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(NUM_CTX));
   // R10
   pool_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid |-> !c_park[ret_tid]);
endmodule

// File: rtl/mtf_opq.sv
module mtf_opq #(
   parameter int Q_WORDS = 4,
   parameter int WORD_W  = 64,
   parameter int TID_W   = 4,
   localparam int PTR_W  = $clog2(Q_WORDS),
   localparam int CNT_W  = $clog2(Q_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [TID_W-1:0]  push_tid,
   input  logic [WORD_W-1:0] push_word,
   input  logic              pop,
   output logic              full,
   output logic              empty,
   output logic [TID_W-1:0]  head_tid,
   output logic [WORD_W-1:0] head_word
);
   if (Q_WORDS < 2) begin : g_bad_depth
      $error("Q_WORDS must be at least 2");
   end

   logic [WORD_W-1:0] st_word [Q_WORDS];
   logic [TID_W-1:0]  st_tid  [Q_WORDS];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  cnt;

   if (Q_WORDS == (1 << PTR_W)) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(Q_WORDS - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(Q_WORDS - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign full      = cnt == CNT_W'(Q_WORDS);
   assign empty     = cnt == '0;
   assign head_tid  = st_tid[rd_ptr];
   assign head_word = st_word[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         for (int i = 0; i < Q_WORDS; i++) begin
            st_word[i] <= '0;
            st_tid[i]  <= '0;
         end
      end else begin
         if (push) begin
            st_word[wr_ptr] <= push_word;
            st_tid[wr_ptr]  <= push_tid;
            wr_ptr          <= wr_nxt;
         end
         if (pop) rd_ptr <= rd_nxt;
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      end
   end

   // R6
   opq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R11
   opq_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/mtf_out_arb.sv
module mtf_out_arb #(
   parameter int NUM_ACT = 4,
   localparam int SLOT_W = $clog2(NUM_ACT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ACT-1:0] has_data,
   input  logic               take,
   output logic               valid,
   output logic [SLOT_W-1:0]  sel,
   output logic [NUM_ACT-1:0] pop
);
   logic [SLOT_W-1:0] rr, lk_sel, scan_sel;
   logic              lk_v, scan_hit;

   always_comb begin
      scan_hit = 1'b0;
      scan_sel = '0;
      for (int k = 0; k < NUM_ACT; k++) begin
         int idx;
         idx = (int'(rr) + k) % NUM_ACT;
         if (!scan_hit && has_data[idx]) begin
            scan_hit = 1'b1;
            scan_sel = SLOT_W'(idx);
         end
      end
      sel   = lk_v ? lk_sel : scan_sel;
      valid = has_data[sel];
      pop   = '0;
      if (valid && take) pop[sel] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr     <= '0;
         lk_v   <= 1'b0;
         lk_sel <= '0;
      end else if (valid && take) begin
         rr   <= SLOT_W'((int'(sel) + 1) % NUM_ACT);
         lk_v <= 1'b0;
      end else if (valid) begin
         lk_v   <= 1'b1;
         lk_sel <= sel;
      end
   end

   // R11
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !take |=> valid && sel == $past(sel));
   // R11
   out_pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pop));
endmodule

// File: rtl/mt_fetch_queue.sv
module mt_fetch_queue #(
   parameter int          NUM_CTX       = 16,
   parameter int          NUM_ACT       = 4,
   parameter int          Q_WORDS       = 4,
   parameter int          ADDR_W        = 32,
   parameter int          WORD_W        = 64,
   parameter int          POST_BR_WORDS = 2,
   parameter logic [3:0]  BR_CODE       = 4'hF,
   localparam int TID_W  = $clog2(NUM_CTX),
   localparam int SLOT_W = $clog2(NUM_ACT),
   localparam int LANES  = WORD_W / mtf_pkg::OP_W,
   localparam int STEP   = WORD_W / 8,
   localparam int POST_W = $clog2(POST_BR_WORDS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctx_ld_valid_i,
   input  logic [TID_W-1:0]  ctx_ld_tid_i,
   input  logic [ADDR_W-1:0] ctx_ld_ip_i,
   input  logic              br_res_valid_i,
   input  logic [TID_W-1:0]  br_res_tid_i,
   input  logic [ADDR_W-1:0] br_res_ip_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_gnt_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   input  logic              mem_miss_i,
   output logic              op_valid_o,
   input  logic              op_ready_i,
   output logic [WORD_W-1:0] op_word_o,
   output logic [TID_W-1:0]  op_tid_o
);
   import mtf_pkg::*;

   if (NUM_ACT < 2 || NUM_ACT > NUM_CTX) begin : g_bad_act
      $error("NUM_ACT must lie between 2 and NUM_CTX");
   end
   if (WORD_W % OP_W != 0) begin : g_bad_word
      $error("WORD_W must be a multiple of the op width");
   end

   // active slot state
   logic [NUM_ACT-1:0] s_occ, s_br;
   logic [TID_W-1:0]   s_tid  [NUM_ACT];
   logic [ADDR_W-1:0]  s_ip   [NUM_ACT];
   logic [POST_W-1:0]  s_post [NUM_ACT];
   logic [SLOT_W-1:0]  f_rr;

   // queue signals
   logic [NUM_ACT-1:0] q_full, q_empty, q_push, q_pop;
   logic [TID_W-1:0]   q_tid  [NUM_ACT];
   logic [WORD_W-1:0]  q_word [NUM_ACT];

   // fetch selection
   logic [NUM_ACT-1:0] cand;
   logic               f_hit;
   logic [SLOT_W-1:0]  f_sel;

   always_comb begin
      cand  = s_occ & ~q_full;
      f_hit = 1'b0;
      f_sel = '0;
      for (int k = 0; k < NUM_ACT; k++) begin
         int idx;
         idx = (int'(f_rr) + k) % NUM_ACT;
         if (!f_hit && cand[idx]) begin
            f_hit = 1'b1;
            f_sel = SLOT_W'(idx);
         end
      end
   end

   assign mem_req_o  = f_hit;
   assign mem_addr_o = s_ip[f_sel];

   // branch pre-scan over every lane of the returned word
   logic [LANES-1:0] lane_br;
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_br[l] = lane_is_branch(mem_rdata_i[l*OP_W +: OP_W], BR_CODE);
   end

   logic   fire, miss, store, cur_br, post_done, mark, leave, wb;
   leave_e why;

   always_comb begin
      fire      = f_hit && mem_gnt_i;
      miss      = fire && mem_miss_i;
      store     = fire && !mem_miss_i;
      cur_br    = s_br[f_sel];
      post_done = (int'(s_post[f_sel]) + 1) == POST_BR_WORDS;
      mark      = store && !cur_br && (|lane_br);
      why       = LEAVE_NONE;
      if (miss) why = LEAVE_MISS;
      else if (store && cur_br && post_done) why = LEAVE_BRANCH;
      else if (mark && POST_BR_WORDS == 0) why = LEAVE_BRANCH;
      leave = why != LEAVE_NONE;
      wb    = (why == LEAVE_MISS) && !cur_br;
   end

   // admission into the lowest free slot
   logic              a_hit, adm_pop, adm_avail;
   logic [SLOT_W-1:0] a_slot;
   logic [TID_W-1:0]  adm_tid;
   logic [ADDR_W-1:0] adm_ip;

   always_comb begin
      a_hit  = 1'b0;
      a_slot = '0;
      for (int k = 0; k < NUM_ACT; k++) begin
         if (!a_hit && !s_occ[k]) begin
            a_hit  = 1'b1;
            a_slot = SLOT_W'(k);
         end
      end
      adm_pop = a_hit && adm_avail;
   end

   mtf_ctx_pool #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) pool_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_valid   (ctx_ld_valid_i),
      .ld_tid     (ctx_ld_tid_i),
      .ld_ip      (ctx_ld_ip_i),
      .rs_valid   (br_res_valid_i),
      .rs_tid     (br_res_tid_i),
      .rs_ip      (br_res_ip_i),
      .mark_valid (mark),
      .mark_tid   (s_tid[f_sel]),
      .ret_valid  (leave),
      .ret_tid    (s_tid[f_sel]),
      .ret_wb     (wb),
      .ret_ip     (s_ip[f_sel]),
      .adm_pop    (adm_pop),
      .adm_avail  (adm_avail),
      .adm_tid    (adm_tid),
      .adm_ip     (adm_ip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_occ <= '0;
         s_br  <= '0;
         f_rr  <= '0;
         for (int s = 0; s < NUM_ACT; s++) begin
            s_tid[s]  <= '0;
            s_ip[s]   <= '0;
            s_post[s] <= '0;
         end
      end else begin
         for (int s = 0; s < NUM_ACT; s++) begin
            if (adm_pop && a_slot == SLOT_W'(s)) begin
               s_occ[s]  <= 1'b1;
               s_tid[s]  <= adm_tid;
               s_ip[s]   <= adm_ip;
               s_br[s]   <= 1'b0;
               s_post[s] <= '0;
            end
            if (fire && f_sel == SLOT_W'(s)) begin
               if (leave) s_occ[s] <= 1'b0;
               if (store) s_ip[s] <= s_ip[s] + ADDR_W'(STEP);
               if (mark) begin
                  s_br[s]   <= 1'b1;
                  s_post[s] <= '0;
               end else if (store && cur_br) begin
                  s_post[s] <= s_post[s] + 1'b1;
               end
            end
         end
         if (fire) f_rr <= SLOT_W'((int'(f_sel) + 1) % NUM_ACT);
      end
   end

   // per-slot opcode queues
   for (genvar s = 0; s < NUM_ACT; s++) begin : g_q
      assign q_push[s] = store && f_sel == SLOT_W'(s);
      mtf_opq #(.Q_WORDS(Q_WORDS), .WORD_W(WORD_W), .TID_W(TID_W)) q_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (q_push[s]),
         .push_tid  (s_tid[s]),
         .push_word (mem_rdata_i),
         .pop       (q_pop[s]),
         .full      (q_full[s]),
         .empty     (q_empty[s]),
         .head_tid  (q_tid[s]),
         .head_word (q_word[s])
      );
   end

   logic [SLOT_W-1:0] o_sel;

   mtf_out_arb #(.NUM_ACT(NUM_ACT)) arb_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .has_data (~q_empty),
      .take     (op_ready_i),
      .valid    (op_valid_o),
      .sel      (o_sel),
      .pop      (q_pop)
   );

   assign op_word_o = q_word[o_sel];
   assign op_tid_o  = q_tid[o_sel];

   // R5
   fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> s_ip[$past(f_sel)] == $past(mem_addr_o) + ADDR_W'(STEP));
   // R9
   miss_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> !s_occ[$past(f_sel)]);
   // R8
   branch_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (store && cur_br && post_done) |=> !s_occ[$past(f_sel)]);
   // R6
   full_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !q_full[f_sel]);
endmodule

// File: tb/mt_fetch_queue_tb.sv
module mt_fetch_queue_tb_top;
   localparam int NA   = 4;
   localparam int NC   = 16;
   localparam int QW   = 4;
   localparam int POST = 2;
   localparam int NCYC = 3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_v = 1'b0, rs_v = 1'b0, gnt = 1'b0, rdy = 1'b0;
   logic [3:0]  ld_t = '0, rs_t = '0;
   logic [31:0] ld_ip = '0, rs_ip = '0;
   logic        req, ov, miss;
   logic [31:0] addr;
   logic [63:0] rdata, oword;
   logic [3:0]  otid;
   bit          miss_arm = 1'b0;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [63:0] mk_word(input logic [31:0] a);
      logic [63:0] w;
      for (int k = 0; k < 4; k++) begin
         logic [3:0] nib;
         nib = (k == 1 && a[8:3] == 6'd5) ? 4'hF : 4'(k);
         w[k*16 +: 16] = {nib, a[11:0] ^ 12'(k * 37)};
      end
      return w;
   endfunction

   function automatic bit is_miss(input logic [31:0] a, input bit arm);
      return arm && a[8:3] == 6'd2;
   endfunction

   assign rdata = mk_word(addr);
   assign miss  = is_miss(addr, miss_arm);

   mt_fetch_queue dut_i (
      .clk(clk), .rst_n(rst_n),
      .ctx_ld_valid_i(ld_v), .ctx_ld_tid_i(ld_t), .ctx_ld_ip_i(ld_ip),
      .br_res_valid_i(rs_v), .br_res_tid_i(rs_t), .br_res_ip_i(rs_ip),
      .mem_req_o(req), .mem_addr_o(addr), .mem_gnt_i(gnt),
      .mem_rdata_i(rdata), .mem_miss_i(miss),
      .op_valid_o(ov), .op_ready_i(rdy), .op_word_o(oword), .op_tid_o(otid)
   );

   // behavioural reference model
   bit          m_cv[NC], m_cpend[NC], m_cpark[NC];
   logic [31:0] m_cip[NC];
   int          pend_age[NC], gen[NC];
   int          rq[$];
   bit          m_occ[NA], m_sbr[NA];
   int          m_stid[NA], m_spost[NA];
   logic [31:0] m_sip[NA];
   logic [63:0] mqw[NA][$];
   int          mqt[NA][$];
   int          m_frr = 0, m_orr = 0, m_lsel = 0;
   bit          m_lock = 0;
   bit          p_oval, p_fc;
   int          p_osel, p_fsel;
   int n_brret = 0, n_miss = 0, n_unpark = 0, n_full = 0, n_ign = 0, n_wait = 0, n_requeue = 0;

   task automatic chk(input bit ok, input string req_tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
      end
   endtask

   task automatic predict();
      p_oval = 0; p_osel = 0;
      if (m_lock) begin p_oval = 1; p_osel = m_lsel; end
      else for (int k = 0; k < NA; k++) begin
         int i; i = (m_orr + k) % NA;
         if (!p_oval && mqw[i].size() > 0) begin p_oval = 1; p_osel = i; end
      end
      p_fc = 0; p_fsel = 0;
      for (int k = 0; k < NA; k++) begin
         int i; i = (m_frr + k) % NA;
         if (!p_fc && m_occ[i] && mqw[i].size() < QW) begin p_fc = 1; p_fsel = i; end
      end
      for (int i = 0; i < NA; i++) if (m_occ[i] && mqw[i].size() == QW) n_full++;
      if (rq.size() > 0 && m_occ[0] && m_occ[1] && m_occ[2] && m_occ[3]) n_wait++;
   endtask

   task automatic model_step();
      int a, at, s, t;
      logic [31:0] aip, fa;
      logic [63:0] w;
      bit adm, ret, mark, wb, ld_ok, rs_ok, unpark, park;
      a = -1;
      for (int i = 0; i < NA; i++) if (a < 0 && !m_occ[i]) a = i;
      adm = (a >= 0) && rq.size() > 0;
      at  = adm ? rq[0] : 0;
      aip = m_cip[at];
      if (p_oval && rdy) begin
         void'(mqw[p_osel].pop_front()); void'(mqt[p_osel].pop_front());
         m_orr = (p_osel + 1) % NA; m_lock = 0;
      end else if (p_oval) begin m_lock = 1; m_lsel = p_osel; end
      ret = 0; mark = 0; wb = 0; t = 0; fa = '0;
      if (p_fc && gnt) begin
         s = p_fsel; t = m_stid[s]; fa = m_sip[s]; w = mk_word(fa);
         if (is_miss(fa, miss_arm)) begin ret = 1; wb = !m_sbr[s]; n_miss++; end
         else begin
            mqw[s].push_back(w); mqt[s].push_back(t);
            m_sip[s] = fa + 32'd8;
            if (m_sbr[s]) begin
               m_spost[s]++;
               if (m_spost[s] == POST) begin ret = 1; n_brret++; end
            end else if (w[31:28] == 4'hF) begin
               mark = 1; m_sbr[s] = 1; m_spost[s] = 0;
               if (POST == 0) ret = 1;
            end
         end
         if (ret) m_occ[s] = 0;
         m_frr = (s + 1) % NA;
      end
      ld_ok  = ld_v && !m_cv[ld_t];
      if (ld_v && !ld_ok) n_ign++;
      rs_ok  = rs_v && m_cv[rs_t];
      unpark = rs_ok && m_cpark[rs_t];
      park   = ret && (m_cpend[t] || mark) && !(rs_ok && int'(rs_t) == t);
      if (adm) void'(rq.pop_front());
      if (ld_ok) rq.push_back(int'(ld_t));
      if (unpark) rq.push_back(int'(rs_t));
      if (ret && !park) begin rq.push_back(t); n_requeue++; end
      if (ld_ok) begin m_cv[ld_t] = 1; m_cip[ld_t] = ld_ip; m_cpend[ld_t] = 0; m_cpark[ld_t] = 0; end
      if (mark) begin m_cpend[t] = 1; pend_age[t] = 0; end
      if (ret && park) m_cpark[t] = 1;
      if (wb) m_cip[t] = fa;
      if (rs_ok) begin
         m_cip[rs_t] = rs_ip; m_cpend[rs_t] = 0;
         if (unpark) begin m_cpark[rs_t] = 0; n_unpark++; end
      end
      if (adm) begin
         m_occ[a] = 1; m_stid[a] = at; m_sip[a] = aip; m_sbr[a] = 0; m_spost[a] = 0;
      end
      for (int i = 0; i < NC; i++) if (m_cpend[i]) pend_age[i]++;
   endtask

   task automatic drive(input int cyc);
      int load_tids[6] = '{3, 7, 0, 12, 5, 9};
      ld_v = 0; rs_v = 0;
      rst_n = (cyc >= 4);
      gnt = (cyc % 5) != 4;
      rdy = (cyc >= 200 && cyc < 260) ? 1'b0 : ((cyc % 3) != 1);
      miss_arm = (cyc >= 400 && cyc < 700);
      if (cyc >= 22 && cyc < 46 && cyc % 4 == 2) begin
         ld_v = 1; ld_t = 4'(load_tids[(cyc - 22) / 4]);
         ld_ip = {16'h0, ld_t, 12'h000};
      end
      if (cyc == 150) begin ld_v = 1; ld_t = 4'd3; ld_ip = 32'hDEAD_0000; end
      if (cyc > 50 && cyc % 4 == 0) begin
         for (int i = 0; i < NC; i++) begin
            if (!rs_v && m_cpend[i] && pend_age[i] >= 12) begin
               rs_v = 1; rs_t = 4'(i); gen[i]++;
               rs_ip = {16'h0, 4'(i), 3'(gen[i]), 9'h000};
            end
         end
      end
   endtask

   initial begin
      for (int i = 0; i < NC; i++) begin
         m_cv[i] = 0; m_cpend[i] = 0; m_cpark[i] = 0; m_cip[i] = '0; pend_age[i] = 0; gen[i] = 0;
      end
      for (int i = 0; i < NA; i++) begin
         m_occ[i] = 0; m_sbr[i] = 0; m_stid[i] = 0; m_spost[i] = 0; m_sip[i] = '0;
      end
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         @(negedge clk);
         drive(cyc);
         #2;
         predict();
         if (cyc <= 4) begin
            // R1 reset state
            chk(ov == 1'b0, "R1 op_valid", 64'(ov), 64'd0);
            chk(req == 1'b0, "R1 mem_req", 64'(req), 64'd0);
         end
         if (cyc < 23) chk(req == 1'b0, "R3 no fetch from null contexts", 64'(req), 64'd0);
         // R4 R5 R12 fetch order and address
         chk(req == p_fc, "R5 mem_req", 64'(req), 64'(p_fc));
         if (p_fc && req) chk(addr == m_sip[p_fsel], "R4 R5 R12 mem_addr", 64'(addr), 64'(m_sip[p_fsel]));
         // R11 output order
         chk(ov == p_oval, "R11 op_valid", 64'(ov), 64'(p_oval));
         if (p_oval && ov) begin
            chk(oword == mqw[p_osel][0], "R11 op_word", oword, mqw[p_osel][0]);
            chk(int'(otid) == mqt[p_osel][0], "R7 op_tid", 64'(otid), 64'(mqt[p_osel][0]));
         end
         @(posedge clk);
         if (rst_n) model_step();
      end
      chk(n_ign > 0, "R2 write to live context ignored", 64'(n_ign), 64'd1);
      chk(n_wait > 0, "R4 threads waiting with all slots busy", 64'(n_wait), 64'd1);
      chk(n_full > 0, "R6 full queue reached", 64'(n_full), 64'd1);
      chk(n_brret > 0, "R8 branch rotation", 64'(n_brret), 64'd1);
      chk(n_miss > 0, "R9 miss rotation", 64'(n_miss), 64'd1);
      chk(n_unpark > 0, "R10 parked thread resumed", 64'(n_unpark), 64'd1);
      chk(n_requeue > 0, "R12 requeue at tail", 64'(n_requeue), 64'd1);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule